// File: doc/BRIEF.md
# Serial Flash Boot-Mode Prober

This controller looks for a valid second-stage boot image on an external serial flash when it is not known which SPI clock mode the flash expects. After a start pulse it tries the four SPI modes one after another. In each attempt it selects the flash, sends a plain read command for address zero and clocks in the first 256 bytes. Every received byte is passed out on a byte write port, so a local buffer ends up holding the image.

While the bytes arrive, a running 32-bit sum is kept over the first 252 bytes. The last four bytes are assembled little-endian into the expected value. If the two agree, the search stops, success is raised and the working mode is reported. If no mode produces a matching image, a fallback flag asks the system to enter its download path instead.

The SPI clock runs at the system clock divided by a build-time parameter. Between attempts, chip select is released long enough for the flash to see a clean deselect. The new clock idle level is also applied during that time.

Top module: `flash_boot_prober`

## Requirements
- R1: After reset spi_cs_n is 1, and done, success, fallback and buf_we are all 0.
- R2: Each attempt pulls spi_cs_n low once and transfers exactly 260 bytes (4160 SCLK edges). The first four bytes sent on spi_mosi are 0x03, 0x00, 0x00, 0x00, MSB first, and the next 256 bytes are read from spi_miso, MSB first.
- R3: Modes are tried in the order 0, 1, 2, 3. In mode number m, CPOL is bit 1 and CPHA is bit 0. spi_sclk idles at CPOL whenever chip select falls. With CPHA=0, spi_miso is sampled on the leading edge; with CPHA=1, it is sampled on the trailing edge.
- R4: Inside a byte, spi_sclk toggles every SCLK_DIV/2 system clocks, which gives a period of SCLK_DIV clocks.
- R5: Every received image byte i (0 to 255) produces exactly one buf_we pulse with buf_addr = i and buf_wdata = the byte. After the search ends, the buffer holds the bytes of the last attempt.
- R6: An attempt passes when the sum modulo 2^32 of bytes 0 to 251 equals the word {b255,b254,b253,b252}, where byte 252 is the least significant. On a pass, done and success go to 1 and good_mode shows the mode number.
- R7: The first passing mode ends the search, and no further attempt is made.
- R8: If all four modes fail, done and fallback go to 1 and success stays 0. success and fallback are never 1 together.
- R9: Between any two chip-select assertions, spi_cs_n stays high for at least 2*SCLK_DIV system clocks.
- R10: A start pulse during a search is ignored. done, success, fallback and good_mode hold until the next start, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse to begin a search |
| spi_sclk | output | 1 | SPI serial clock |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | Data to flash |
| spi_miso | input | 1 | Data from flash |
| buf_we | output | 1 | Buffer byte write strobe |
| buf_addr | output | $clog2(IMG_BYTES) | Buffer byte address |
| buf_wdata | output | 8 | Buffer byte data |
| done | output | 1 | Search finished |
| success | output | 1 | A valid image was found |
| fallback | output | 1 | Request for the download path |
| good_mode | output | 2 | Passing SPI mode number |

## Verification
Two decisions can fall on the same cycle when the final mode is reached: a passing verdict and the "all modes tried" fallback. They collide when the flash model answers only in mode 3. The bench runs that case and requires success=1, fallback=0 and good_mode=3 after four attempts. The image bytes for every model mode are computed arithmetically, and so are the corrupted and byte-swapped checksum variants. Attempt counts, per-window edge counts, idle levels, chip-select gaps and buffer contents are checked against values derived from the requirements.

// File: rtl/fbp_pkg.sv
package fbp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GAP,
    ST_XFER,
    ST_CHECK,
    ST_DONE
  } fbp_state_e;

  localparam int unsigned READ_OPCODE = 8'h03;
  localparam int unsigned ADDR_BYTES  = 3;
  localparam int unsigned HDR_BYTES   = 1 + ADDR_BYTES;
endpackage

// File: rtl/fbp_rst_sync.sv
module fbp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/fbp_spi_byte.sv
module fbp_spi_byte #(
  parameter int HALF = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       cpol,
  input  logic       cpha,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic          busy_q, busy_d, done_q, done_d, sclk_q, sclk_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [3:0]    edge_q, edge_d;
  logic [7:0]    txsh_q, txsh_d, rxsh_q, rxsh_d;
  logic          tick, samp;

  assign tick = busy_q && (cnt_q == CW'(HALF - 1));
  // even edge index = leading edge; sample there when phase is 0
  assign samp = cpha ? edge_q[0] : ~edge_q[0];

  always_comb begin
    busy_d = busy_q;
    done_d = 1'b0;
    sclk_d = sclk_q;
    cnt_d  = cnt_q;
    edge_d = edge_q;
    txsh_d = txsh_q;
    rxsh_d = rxsh_q;
    if (!busy_q) begin
      sclk_d = cpol;
      if (start) begin
        busy_d = 1'b1;
        cnt_d  = '0;
        edge_d = '0;
        txsh_d = tx;
      end
    end else if (tick) begin
      cnt_d  = '0;
      sclk_d = ~sclk_q;
      edge_d = edge_q + 4'd1;
      if (samp) rxsh_d = {rxsh_q[6:0], miso};
      else if (edge_q != 4'd0 && edge_q != 4'd15) txsh_d = {txsh_q[6:0], 1'b0};
      if (edge_q == 4'd15) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      sclk_q <= 1'b0;
      cnt_q  <= '0;
      edge_q <= '0;
      txsh_q <= '0;
      rxsh_q <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      sclk_q <= sclk_d;
      cnt_q  <= cnt_d;
      edge_q <= edge_d;
      txsh_q <= txsh_d;
      rxsh_q <= rxsh_d;
    end
  end

  assign sclk = sclk_q;
  assign mosi = txsh_q[7];
  assign busy = busy_q;
  assign done = done_q;
  assign rx   = rxsh_q;
endmodule

// File: rtl/fbp_img_check.sv
module fbp_img_check #(
  parameter int IMG_BYTES = 256
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clear,
  input  logic                         byte_vld,
  input  logic [$clog2(IMG_BYTES)-1:0] byte_idx,
  input  logic [7:0]                   byte_val,
  output logic                         match
);
  localparam int AW        = $clog2(IMG_BYTES);
  localparam int SUM_BYTES = IMG_BYTES - 4;

  logic [31:0] sum_q, sum_d, exp_q, exp_d;

  always_comb begin
    sum_d = sum_q;
    exp_d = exp_q;
    if (clear) begin
      sum_d = '0;
      exp_d = '0;
    end else if (byte_vld) begin
      if (byte_idx < AW'(SUM_BYTES)) sum_d = sum_q + {24'd0, byte_val};
      else                           exp_d = {byte_val, exp_q[31:8]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
      exp_q <= '0;
    end else begin
      sum_q <= sum_d;
      exp_q <= exp_d;
    end
  end

  assign match = (sum_q == exp_q);
endmodule

// File: rtl/flash_boot_prober.sv
module flash_boot_prober
  import fbp_pkg::*;
#(
  parameter int SCLK_DIV  = 4,
  parameter int IMG_BYTES = 256
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  output logic                         spi_sclk,
  output logic                         spi_cs_n,
  output logic                         spi_mosi,
  input  logic                         spi_miso,
  output logic                         buf_we,
  output logic [$clog2(IMG_BYTES)-1:0] buf_addr,
  output logic [7:0]                   buf_wdata,
  output logic                         done,
  output logic                         success,
  output logic                         fallback,
  output logic [1:0]                   good_mode
);
  localparam int AW         = $clog2(IMG_BYTES);
  localparam int XFER_BYTES = IMG_BYTES + HDR_BYTES;
  localparam int NW         = $clog2(XFER_BYTES);
  localparam int GAP_CYC    = 2 * SCLK_DIV;
  localparam int GW         = $clog2(GAP_CYC + 1);

  logic rst_s_n;
  fbp_state_e state_q, state_d;
  logic [1:0]    mode_q, mode_d, gmode_q, gmode_d;
  logic [NW-1:0] nbyte_q, nbyte_d;
  logic [GW-1:0] gap_q, gap_d;
  logic          go_q, go_d, cs_n_q, cs_n_d;
  logic          done_q, done_d, succ_q, succ_d, fb_q, fb_d;
  logic          we_q, we_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [7:0]    wdata_q, wdata_d, tx_byte, eng_rx;
  logic          eng_done, eng_busy, img_ok, img_vld;
  logic [AW-1:0] img_idx;

  fbp_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_s_n));

  assign tx_byte = (nbyte_q == '0) ? 8'(READ_OPCODE) : 8'h00;

  fbp_spi_byte #(.HALF(SCLK_DIV / 2)) u_shift (
    .clk(clk), .rst_n(rst_s_n), .start(go_q), .cpol(mode_q[1]), .cpha(mode_q[0]),
    .tx(tx_byte), .miso(spi_miso), .sclk(spi_sclk), .mosi(spi_mosi),
    .busy(eng_busy), .done(eng_done), .rx(eng_rx)
  );

  assign img_vld = (state_q == ST_XFER) && eng_done && (nbyte_q >= NW'(HDR_BYTES));
  assign img_idx = AW'(nbyte_q - NW'(HDR_BYTES));

  fbp_img_check #(.IMG_BYTES(IMG_BYTES)) u_sum (
    .clk(clk), .rst_n(rst_s_n), .clear(state_q == ST_GAP),
    .byte_vld(img_vld), .byte_idx(img_idx), .byte_val(eng_rx), .match(img_ok)
  );

  always_comb begin
    state_d = state_q;
    mode_d  = mode_q;
    gmode_d = gmode_q;
    nbyte_d = nbyte_q;
    gap_d   = gap_q;
    go_d    = 1'b0;
    cs_n_d  = cs_n_q;
    done_d  = done_q;
    succ_d  = succ_q;
    fb_d    = fb_q;
    we_d    = 1'b0;
    addr_d  = addr_q;
    wdata_d = wdata_q;
    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          state_d = ST_GAP;
          mode_d  = 2'd0;
          gmode_d = 2'd0;
          gap_d   = '0;
          done_d  = 1'b0;
          succ_d  = 1'b0;
          fb_d    = 1'b0;
        end
      end
      ST_GAP: begin
        if (gap_q == GW'(GAP_CYC - 1)) begin
          state_d = ST_XFER;
          cs_n_d  = 1'b0;
          nbyte_d = '0;
          go_d    = 1'b1;
        end else begin
          gap_d = gap_q + GW'(1);
        end
      end
      ST_XFER: begin
        if (eng_done && !eng_busy) begin
          if (img_vld) begin
            we_d    = 1'b1;
            addr_d  = img_idx;
            wdata_d = eng_rx;
          end
          if (nbyte_q == NW'(XFER_BYTES - 1)) begin
            state_d = ST_CHECK;
            cs_n_d  = 1'b1;
          end else begin
            nbyte_d = nbyte_q + NW'(1);
            go_d    = 1'b1;
          end
        end
      end
      ST_CHECK: begin
        if (img_ok) begin
          state_d = ST_DONE;
          done_d  = 1'b1;
          succ_d  = 1'b1;
          gmode_d = mode_q;
        end else if (mode_q == 2'd3) begin
          state_d = ST_DONE;
          done_d  = 1'b1;
          fb_d    = 1'b1;
        end else begin
          state_d = ST_GAP;
          mode_d  = mode_q + 2'd1;
          gap_d   = '0;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      state_q <= ST_IDLE;
      mode_q  <= '0;
      gmode_q <= '0;
      nbyte_q <= '0;
      gap_q   <= '0;
      go_q    <= 1'b0;
      cs_n_q  <= 1'b1;
      done_q  <= 1'b0;
      succ_q  <= 1'b0;
      fb_q    <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      gmode_q <= gmode_d;
      nbyte_q <= nbyte_d;
      gap_q   <= gap_d;
      go_q    <= go_d;
      cs_n_q  <= cs_n_d;
      done_q  <= done_d;
      succ_q  <= succ_d;
      fb_q    <= fb_d;
      we_q    <= we_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
    end
  end

  assign spi_cs_n  = cs_n_q;
  assign buf_we    = we_q;
  assign buf_addr  = addr_q;
  assign buf_wdata = wdata_q;
  assign done      = done_q;
  assign success   = succ_q;
  assign fallback  = fb_q;
  assign good_mode = gmode_q;
endmodule

// File: rtl/fbp_prober_chk.sv
module fbp_prober_chk #(
  parameter int SCLK_DIV = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       spi_cs_n,
  input logic       spi_sclk,
  input logic [1:0] mode_q,
  input logic       buf_we,
  input logic       done,
  input logic       success,
  input logic       fallback
);
  localparam int GAP_CYC = 2 * SCLK_DIV;
  localparam int GW      = $clog2(GAP_CYC + 1);

  logic [GW-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         hi_cnt <= GW'(GAP_CYC);
    else if (!spi_cs_n)                 hi_cnt <= '0;
    else if (hi_cnt != GW'(GAP_CYC))    hi_cnt <= hi_cnt + GW'(1);
  end

  p_verdict_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(success && fallback));

  p_success_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    success |-> done);

  p_idle_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> (spi_sclk == mode_q[1]));

  p_mode_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != $past(mode_q)) |-> (mode_q == $past(mode_q) + 2'd1 || mode_q == 2'd0));

  p_write_in_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> $past(!spi_cs_n));

  p_done_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  p_cs_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> (hi_cnt >= GW'(GAP_CYC)));
endmodule

bind flash_boot_prober fbp_prober_chk #(.SCLK_DIV(SCLK_DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
  .mode_q(mode_q), .buf_we(buf_we), .done(done), .success(success), .fallback(fallback)
);

// File: tb/flash_boot_prober_test.sv
module flash_boot_prober_test;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 2;
  localparam int NB         = 256;

  logic clk, rst_n, start, spi_sclk, spi_cs_n, spi_mosi, spi_miso;
  logic buf_we, done, success, fallback;
  logic [7:0] buf_addr, buf_wdata;
  logic [1:0] good_mode;

  flash_boot_prober #(.SCLK_DIV(DIV), .IMG_BYTES(NB)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .buf_we(buf_we), .buf_addr(buf_addr),
    .buf_wdata(buf_wdata), .done(done), .success(success), .fallback(fallback),
    .good_mode(good_mode)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // flash model state
  logic [7:0] img [NB];
  logic [1:0] m_mode;
  logic       m_bad, prev_sclk, prev_cs, miso_r;
  int         m_bits;
  logic [31:0] m_cmd;
  // monitor state
  logic [7:0] bufm [NB];
  int attempts, toggles, bad_win, min_iv, iv, iv_ok, hi_cyc, min_gap, cpol_err;
  int cmd_hits, wr_cnt, addr_err;

  assign spi_miso = miso_r;

  initial begin
    miso_r = 1'b1; prev_cs = 1'b1; prev_sclk = 1'b0; m_bad = 1'b0;
    m_bits = 0; m_cmd = '0; m_mode = 2'd0; hi_cyc = 0;
  end

  always @(negedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
    if (buf_we) begin
      if (int'(buf_addr) != wr_cnt % NB) addr_err++;
      bufm[buf_addr] = buf_wdata;
      wr_cnt++;
    end
    if (spi_cs_n) begin
      if (!prev_cs) begin
        if (toggles != 260 * 16) bad_win++;
      end
      miso_r = 1'b1;
      prev_cs = 1'b1;
      hi_cyc++;
    end else if (prev_cs) begin
      if (hi_cyc < min_gap) min_gap = hi_cyc;
      hi_cyc = 0;
      if (spi_sclk != ((attempts >> 1) & 1)) cpol_err++;
      attempts++;
      toggles = 0; iv = 0; iv_ok = 0;
      m_bad = (spi_sclk != m_mode[1]);
      m_bits = 0; m_cmd = '0;
      prev_sclk = spi_sclk;
      prev_cs = 1'b0;
    end else begin
      iv++;
      if (spi_sclk != prev_sclk) begin
        logic lead, samp;
        int d;
        toggles++;
        if (iv_ok && iv < min_iv) min_iv = iv;
        iv = 0; iv_ok = 1;
        lead = (spi_sclk != m_mode[1]);
        samp = m_mode[0] ? !lead : lead;
        if (samp) begin
          if (m_bits < 32) m_cmd = {m_cmd[30:0], spi_mosi};
          m_bits++;
          if (m_bits == 32 && m_cmd == 32'h0300_0000 && !m_bad) cmd_hits++;
        end else begin
          d = m_bits - 32;
          if (!m_bad && m_bits >= 32 && m_cmd == 32'h0300_0000 && d < NB * 8)
            miso_r = img[d / 8][7 - (d % 8)];
          else
            miso_r = 1'b1;
        end
        prev_sclk = spi_sclk;
      end
    end
  end

  // kind 0: valid little-endian sum, 1: sum off by one, 2: sum stored big-endian
  task automatic build_img(input int seed, input int kind);
    logic [31:0] s;
    s = '0;
    for (int i = 0; i < NB - 4; i++) begin
      img[i] = 8'((i * 37 + seed * 11 + 5) ^ (i >> 3));
      s = s + {24'd0, img[i]};
    end
    if (kind == 1) s = s + 32'd1;
    for (int k = 0; k < 4; k++)
      img[NB - 4 + k] = (kind == 2) ? s[8*(3-k) +: 8] : s[8*k +: 8];
  endtask

  task automatic run(input logic [1:0] mm, input int kind, input bit poke);
    int w;
    m_mode = mm;
    build_img(int'(mm), kind);
    attempts = 0; bad_win = 0; min_iv = 1000; min_gap = 1000; cpol_err = 0;
    cmd_hits = 0; wr_cnt = 0; addr_err = 0;
    for (int i = 0; i < NB; i++) bufm[i] = 8'h5A;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(done == 1'b0, "R10 start clears done", int'(done), 0);
    if (poke) begin
      repeat (6000) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    w = 0;
    while (!done && w < 60000) begin @(negedge clk); w++; end
    chk(done == 1'b1, "R6/R8 search completes", int'(done), 1);
  endtask

  task automatic check_common(input string tag);
    chk(bad_win == 0, {tag, " R2 260-byte windows"}, bad_win, 0);
    chk(min_iv == DIV / 2, {tag, " R4 sclk half period"}, min_iv, DIV / 2);
    chk(min_gap >= 2 * DIV, {tag, " R9 cs high gap"}, min_gap, 2 * DIV);
    chk(cpol_err == 0, {tag, " R3 idle level per mode order"}, cpol_err, 0);
    chk(wr_cnt == NB * attempts, {tag, " R5 write count"}, wr_cnt, NB * attempts);
    chk(addr_err == 0, {tag, " R5 write addresses"}, addr_err, 0);
  endtask

  initial begin
    start = 1'b0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(spi_cs_n == 1'b1, "R1 cs_n reset", int'(spi_cs_n), 1);
    chk({done, success, fallback, buf_we} == 4'b0, "R1 flags reset",
        int'({done, success, fallback, buf_we}), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(spi_cs_n == 1'b1 && done == 1'b0, "R1 idle after release", int'(spi_cs_n), 1);

    // sweep: flash answers in exactly one mode; mode 2 run gets a stray start
    for (int m = 0; m < 4; m++) begin
      int bad;
      run(2'(m), 0, m == 2);
      chk(success == 1'b1, "R6 success", int'(success), 1);
      chk(fallback == 1'b0, "R8 no fallback on pass", int'(fallback), 0);
      chk(int'(good_mode) == m, "R3 good_mode", int'(good_mode), m);
      chk(attempts == m + 1, (m == 2) ? "R7 R10 attempts with stray start" : "R7 attempts",
          attempts, m + 1);
      chk(cmd_hits == 1, "R2 read command seen in matching mode", cmd_hits, 1);
      bad = 0;
      for (int i = 0; i < NB; i++) if (bufm[i] !== img[i]) bad++;
      chk(bad == 0, "R5 buffer holds image", bad, 0);
      check_common("pass");
      repeat (40) @(negedge clk);
      chk(done && success && int'(good_mode) == m, "R10 verdict held", int'(done), 1);
    end

    // corrupted sum: every mode fails
    run(2'd0, 1, 1'b0);
    chk(fallback == 1'b1 && success == 1'b0, "R8 fallback on bad sum",
        int'({success, fallback}), 1);
    chk(attempts == 4, "R8 all four modes tried", attempts, 4);
    begin
      int ff;
      ff = 0;
      for (int i = 0; i < NB; i++) if (bufm[i] != 8'hFF) ff++;
      chk(ff == 0, "R5 buffer holds last (mode 3) attempt", ff, 0);
    end
    check_common("badsum");

    // sum stored with wrong byte order must not pass
    run(2'd1, 2, 1'b0);
    chk(fallback == 1'b1 && success == 1'b0, "R6 byte order of stored sum",
        int'({success, fallback}), 1);
    chk(attempts == 4, "R6 R8 attempts on swapped sum", attempts, 4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule